// File: doc/BRIEF.md
# Exception Priority and Vector Selector

This block sits beside a processor core's control logic and decides which exception is taken when several are pending at once. Each cycle it looks at seven request lines (reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction and supervisor call), removes the two interrupt requests that the current disable flags block, and picks the single winner of a fixed six-level priority. The supervisor call and the undefined instruction share the lowest level.

For the winner it produces a one-hot grant, the entry address and the five-bit code of the privileged mode to enter. The entry addresses are not in priority order, and one word in the table (offset 0x14) is kept free. All results are registered: a request pattern presented in one cycle gives its outputs after the next rising clock edge. The valid strobe is high for exactly that one cycle. Fetch, pipeline flush, return-address capture and status writes belong to the core and are not part of this block.

Top module: `exc_vector_sel`

## Requirements
- R1: Priority from highest to lowest is reset, data abort, fast interrupt, normal interrupt, prefetch abort, then undefined instruction and supervisor call. `exc_grant` bit positions are 0 reset, 1 data abort, 2 fast interrupt, 3 normal interrupt, 4 prefetch abort, 5 undefined instruction and 6 supervisor call. At most one bit is set.
- R2: `exc_vector` is `VEC_BASE` ORed with the winner's offset: reset 0x00, undefined 0x04, supervisor call 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R3: Offset 0x14 is never produced while `exc_valid` is high.
- R4: `exc_mode` codes are 5'b10011 for reset and supervisor call, 5'b10111 for both aborts, 5'b10001 for fast interrupt, 5'b10010 for normal interrupt and 5'b11011 for undefined instruction.
- R5: A high `mask_fast` stops the fast-interrupt request, and a high `mask_norm` stops the normal-interrupt request. Neither flag has any effect on reset, the aborts or the lowest level.
- R6: When the supervisor call and undefined instruction requests are both high, `exc_clash` is 1 in the output cycle and the undefined instruction is selected if nothing higher is pending.
- R7: Outputs follow their inputs by one rising edge. `exc_valid` is 1 exactly in the cycle after an unmasked request is present. In an idle output cycle, valid, grant, vector and mode are all 0.
- R8: A reset request wins over every other request in the same cycle: the grant is 1 in bit 0 only, and the vector is offset 0x00.
- R9: While `rst_n` is low, all outputs are 0.
- R10: With a non-zero `VEC_BASE` (aligned to 32 bytes), each vector carries the base in its upper bits and the offset of R2 in bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| req_rst | input | 1 | Reset exception request |
| req_dab | input | 1 | Data abort request |
| req_fast | input | 1 | Fast interrupt request |
| req_norm | input | 1 | Normal interrupt request |
| req_pab | input | 1 | Prefetch abort request |
| req_svc | input | 1 | Supervisor call request |
| req_undef | input | 1 | Undefined instruction request |
| mask_fast | input | 1 | Disable flag for the fast interrupt |
| mask_norm | input | 1 | Disable flag for the normal interrupt |
| exc_valid | output | 1 | One-cycle strobe for an accepted exception |
| exc_vector | output | ADDR_W | Entry address of the winner |
| exc_mode | output | 5 | Mode code of the winner |
| exc_grant | output | 7 | One-hot winner |
| exc_clash | output | 1 | Supervisor call and undefined instruction were both requested |

## Verification
Every result (grant, vector, mode, valid and clash flag) is due exactly one rising edge after the request pattern that causes it. The bench drives each pattern on a falling edge and compares all outputs on the next falling edge, so only the one register stage lies between stimulus and check. It then drives the next pattern at that same falling edge. The expected values for every cycle are computed by a bench function from the masks and the requests of the previous cycle. The properties in the RTL compare their current outputs with the one-cycle-old inputs, starting from the second edge after reset is released.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;

   localparam int N_SRC   = 7;
   localparam int OFF_W   = 5;
   localparam int MODE_W  = 5;

   // grant bit index equals priority rank (0 = highest)
   typedef enum logic [2:0] {
      SRC_RST  = 3'd0,
      SRC_DAB  = 3'd1,
      SRC_FAST = 3'd2,
      SRC_NORM = 3'd3,
      SRC_PAB  = 3'd4,
      SRC_UND  = 3'd5,
      SRC_SVC  = 3'd6
   } src_e;

   typedef enum logic [MODE_W-1:0] {
      MODE_IDLE = 5'b00000,
      MODE_FAST = 5'b10001,
      MODE_NORM = 5'b10010,
      MODE_SUP  = 5'b10011,
      MODE_ABT  = 5'b10111,
      MODE_UND  = 5'b11011
   } mode_e;

   localparam logic [OFF_W-1:0] RESERVED_OFF = 5'h14;

   function automatic logic [OFF_W-1:0] slot_offset(input int unsigned idx);
      case (idx)
         0:       return 5'h00;
         1:       return 5'h10;
         2:       return 5'h1C;
         3:       return 5'h18;
         4:       return 5'h0C;
         5:       return 5'h04;
         6:       return 5'h08;
         default: return 5'h00;
      endcase
   endfunction

   function automatic mode_e slot_mode(input int unsigned idx);
      case (idx)
         0:       return MODE_SUP;
         1:       return MODE_ABT;
         2:       return MODE_FAST;
         3:       return MODE_NORM;
         4:       return MODE_ABT;
         5:       return MODE_UND;
         6:       return MODE_SUP;
         default: return MODE_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/exc_req_mask.sv
module exc_req_mask
   import exc_sel_pkg::*;
#(
   parameter int N = N_SRC
) (
   input  logic [N-1:0] raw_req,
   input  logic         mask_fast,
   input  logic         mask_norm,
   output logic [N-1:0] eff_req
);

   if (N != N_SRC) begin : g_bad_n
      $error("exc_req_mask: N must equal N_SRC");
   end

   for (genvar i = 0; i < N; i++) begin : g_lane
      if (i == int'(SRC_FAST)) begin : g_fast
         assign eff_req[i] = raw_req[i] & ~mask_fast;
      end else if (i == int'(SRC_NORM)) begin : g_norm
         assign eff_req[i] = raw_req[i] & ~mask_norm;
      end else begin : g_pass
         assign eff_req[i] = raw_req[i];
      end
   end

endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
   parameter int N = 7
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);

   if (N < 2) begin : g_bad_n
      $error("exc_prio_pick: N must be at least 2");
   end

   // seen[i] is high when any lower-index (higher priority) request is set
   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign seen[i+1] = seen[i] | req[i];
      assign grant[i]  = req[i] & ~seen[i];
   end

   assign any = seen[N];

endmodule

// File: rtl/exc_vec_map.sv
module exc_vec_map
   import exc_sel_pkg::*;
#(
   parameter int                N        = N_SRC,
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
   input  logic [N-1:0]        grant,
   output logic [ADDR_W-1:0]   vector,
   output logic [MODE_W-1:0]   mode
);

   if (ADDR_W < 8) begin : g_bad_w
      $error("exc_vec_map: ADDR_W must be at least 8");
   end
   if (VEC_BASE[OFF_W-1:0] != '0) begin : g_bad_base
      $error("exc_vec_map: VEC_BASE must be 32-byte aligned");
   end

   logic [OFF_W-1:0]  off_or;
   logic [MODE_W-1:0] mode_or;

   always_comb begin
      off_or  = '0;
      mode_or = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) begin
            off_or  = off_or  | slot_offset(i);
            mode_or = mode_or | slot_mode(i);
         end
      end
   end

   assign vector = (|grant) ? (VEC_BASE | ADDR_W'(off_or)) : '0;
   assign mode   = mode_or;

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
   import exc_sel_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_rst,
   input  logic              req_dab,
   input  logic              req_fast,
   input  logic              req_norm,
   input  logic              req_pab,
   input  logic              req_svc,
   input  logic              req_undef,
   input  logic              mask_fast,
   input  logic              mask_norm,
   output logic              exc_valid,
   output logic [ADDR_W-1:0] exc_vector,
   output logic [4:0]        exc_mode,
   output logic [6:0]        exc_grant,
   output logic              exc_clash
);

   localparam int N = N_SRC;

   logic [N-1:0]      raw_req, eff_req, nxt_grant;
   logic              nxt_any;
   logic [ADDR_W-1:0] nxt_vector;
   logic [MODE_W-1:0] nxt_mode;

   assign raw_req[SRC_RST]  = req_rst;
   assign raw_req[SRC_DAB]  = req_dab;
   assign raw_req[SRC_FAST] = req_fast;
   assign raw_req[SRC_NORM] = req_norm;
   assign raw_req[SRC_PAB]  = req_pab;
   assign raw_req[SRC_UND]  = req_undef;
   assign raw_req[SRC_SVC]  = req_svc;

   exc_req_mask #(.N(N)) u_mask (
      .raw_req   (raw_req),
      .mask_fast (mask_fast),
      .mask_norm (mask_norm),
      .eff_req   (eff_req)
   );

   exc_prio_pick #(.N(N)) u_pick (
      .req   (eff_req),
      .grant (nxt_grant),
      .any   (nxt_any)
   );

   exc_vec_map #(.N(N), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_map (
      .grant  (nxt_grant),
      .vector (nxt_vector),
      .mode   (nxt_mode)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exc_valid  <= 1'b0;
         exc_vector <= '0;
         exc_mode   <= '0;
         exc_grant  <= '0;
         exc_clash  <= 1'b0;
      end else begin
         exc_valid  <= nxt_any;
         exc_vector <= nxt_vector;
         exc_mode   <= nxt_mode;
         exc_grant  <= nxt_grant;
         exc_clash  <= req_svc & req_undef;
      end
   end

   // armed goes high one edge after reset release, so $past never reaches into reset
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assert_onehot_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(exc_grant));

   assert_valid_tracks_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid == (exc_grant != '0));

   assert_no_reserved_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (exc_vector[OFF_W-1:0] != RESERVED_OFF));

   assert_base_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (exc_vector[ADDR_W-1:OFF_W] == VEC_BASE[ADDR_W-1:OFF_W]));

   assert_reset_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(req_rst)) |-> (exc_grant == 7'b0000001));

   assert_fast_over_norm_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(req_fast && !mask_fast && !req_rst && !req_dab))
      |-> exc_grant[SRC_FAST]);

   assert_norm_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(mask_norm)) |-> !exc_grant[SRC_NORM]);

   assert_fast_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(mask_fast)) |-> !exc_grant[SRC_FAST]);

   assert_clash_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (exc_clash == $past(req_svc && req_undef)));

   assert_clash_not_svc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      exc_clash |-> !exc_grant[SRC_SVC]);

   assert_strobe_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(!req_rst && !req_dab && !req_pab && !req_svc && !req_undef &&
                      !(req_fast && !mask_fast) && !(req_norm && !mask_norm)))
      |-> !exc_valid);

endmodule

// File: tb/tb_exc_vector_sel.sv
module tb_exc_vector_sel;

   localparam logic [31:0] HI_BASE = 32'h2000_0100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [6:0] r = '0;          // index = grant bit position
   logic mf = 1'b0, mn = 1'b0;

   logic        v0, v1, c0, c1;
   logic [31:0] vec0, vec1;
   logic [4:0]  m0, m1;
   logic [6:0]  g0, g1;

   int n_checks = 0;
   int n_fails  = 0;
   bit done = 0;

   always #5 clk = ~clk;

   exc_vector_sel dut (
      .clk(clk), .rst_n(rst_n),
      .req_rst(r[0]), .req_dab(r[1]), .req_fast(r[2]), .req_norm(r[3]),
      .req_pab(r[4]), .req_undef(r[5]), .req_svc(r[6]),
      .mask_fast(mf), .mask_norm(mn),
      .exc_valid(v0), .exc_vector(vec0), .exc_mode(m0),
      .exc_grant(g0), .exc_clash(c0)
   );

   exc_vector_sel #(.VEC_BASE(HI_BASE)) dut_hi (
      .clk(clk), .rst_n(rst_n),
      .req_rst(r[0]), .req_dab(r[1]), .req_fast(r[2]), .req_norm(r[3]),
      .req_pab(r[4]), .req_undef(r[5]), .req_svc(r[6]),
      .mask_fast(mf), .mask_norm(mn),
      .exc_valid(v1), .exc_vector(vec1), .exc_mode(m1),
      .exc_grant(g1), .exc_clash(c1)
   );

   function automatic logic [6:0] want_grant(input logic [6:0] q, input logic f, input logic n);
      logic [6:0] e;
      e = q;
      if (f) e[2] = 1'b0;
      if (n) e[3] = 1'b0;
      for (int i = 0; i < 7; i++) if (e[i]) return 7'(1 << i);
      return '0;
   endfunction

   function automatic logic [4:0] want_off(input logic [6:0] g);
      case (g)
         7'b0000001: return 5'h00;
         7'b0000010: return 5'h10;
         7'b0000100: return 5'h1C;
         7'b0001000: return 5'h18;
         7'b0010000: return 5'h0C;
         7'b0100000: return 5'h04;
         7'b1000000: return 5'h08;
         default:    return 5'h00;
      endcase
   endfunction

   function automatic logic [4:0] want_mode(input logic [6:0] g);
      case (g)
         7'b0000001, 7'b1000000: return 5'b10011;
         7'b0000010, 7'b0010000: return 5'b10111;
         7'b0000100:             return 5'b10001;
         7'b0001000:             return 5'b10010;
         7'b0100000:             return 5'b11011;
         default:                return 5'b00000;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive at a falling edge, check all outputs at the next falling edge
   task automatic step(input logic [6:0] q, input logic f, input logic n, input string why);
      logic [6:0] g;
      r = q; mf = f; mn = n;
      @(negedge clk);
      g = want_grant(q, f, n);
      chk({why, " R1 grant"}, 32'(g0), 32'(g));
      chk({why, " R7 valid"}, 32'(v0), 32'(g != 0));
      chk({why, " R2 vector"}, vec0, (g != 0) ? 32'(want_off(g)) : 32'h0);
      chk({why, " R4 mode"}, 32'(m0), 32'(want_mode(g)));
      chk({why, " R6 clash"}, 32'(c0), 32'(q[5] & q[6]));
      chk({why, " R10 vector"}, vec1, (g != 0) ? (HI_BASE | 32'(want_off(g))) : 32'h0);
      if (v0) chk({why, " R3 no 0x14"}, 32'(vec0[4:0] == 5'h14), 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      logic [6:0] q;
      void'($urandom(32'd1234));
      r = 7'h7F; mf = 1'b0; mn = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 valid in reset", 32'(v0), 0);
      chk("R9 grant in reset", 32'(g0), 0);
      chk("R9 vector in reset", vec0, 0);
      chk("R9 mode in reset", 32'(m0), 0);
      chk("R9 clash in reset", 32'(c0), 0);
      rst_n = 1'b1;
      r = '0;
      @(negedge clk);

      step(7'b0000000, 0, 0, "idle R7");
      step(7'b1111111, 0, 0, "all R8");
      step(7'b0001100, 0, 0, "fast+norm R1");
      step(7'b0001100, 1, 0, "fast masked R5");
      step(7'b0001100, 1, 1, "both masked R5");
      step(7'b0010110, 1, 1, "aborts unmasked R5");
      step(7'b1100000, 0, 0, "clash R6");
      step(7'b1110000, 0, 0, "clash under pab R6");
      step(7'b1000000, 1, 1, "svc only R4");
      step(7'b0100000, 0, 0, "undef only R2");
      step(7'b1111110, 1, 1, "no reset R1");
      step(7'b0000001, 0, 0, "reset only R8");
      step(7'b0010000, 0, 0, "pab only R3");

      for (int k = 0; k < 3000; k++) begin
         for (int b = 0; b < 7; b++) q[b] = (($urandom % 100) < ((b == 0) ? 4 : 15));
         if (($urandom % 4) == 0 && q[5] && q[6]) q[5] = 1'b1;
         step(q, ($urandom % 3) == 0, ($urandom % 3) == 0, "random");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule